// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Pair

This block holds the digital counters of an integer-N frequency synthesizer. In the oscillator clock domain, a programmable counter divides by N = 32 × M + S. It is built from a dual-modulus prescaler that divides by 33 or by 32, a main counter that counts M prescaler cycles, and a swallow counter. The swallow counter keeps the prescaler at 33 for the first S of those cycles. In the reference clock domain, a second counter divides the reference by R. The values of R are picked so that reference clocks of 10.368 MHz, 13.824 MHz and 20.736 MHz all give the same 3.456 MHz comparison rate. Both divided pulses go to a phase-frequency detector, which is outside this block.

A register block supplies M, S and R as small codes. These codes are quasi-static. Each counter latches its code only at the end of its own period, so a new setting never produces a shortened period. A power-up enable holds both counters and all test outputs cleared. Three square-wave test outputs are provided for bring-up:
- the reference pulse train divided by 2,
- the programmable pulse train divided by 2,
- the reference pulse train divided by 512.

Transmit channels use M = 34 with S between 1 and 31. Receive channels use M = 32.

Top module: `pswallow_divpair`

## Requirements
- R1: `prog_pulse` is high for exactly one `vco_clk` cycle once every N = 32 × M + S enabled `vco_clk` cycles, and low otherwise.
- R2: `mc_code` selects M as 2'b00→32, 2'b01→33, 2'b10→34 and 2'b11→35.
- R3: `sc_val` is S as an unsigned 5-bit value. Every value from 0 to 31 gives N = 32 × M + S, including the transmit range 1..31 at M = 34 and the receive case at M = 32.
- R4: `rc_code` selects R as 2'b00→3, 2'b01→4, 2'b10→6 and 2'b11→8. `ref_pulse` is high for one `ref_clk` cycle once every R enabled `ref_clk` cycles.
- R5: A change to `mc_code`, `sc_val` or `rc_code` during a period leaves that period's length unchanged. The change applies from the following period.
- R6: While `pwr_en` is low, both pulse outputs and all three test outputs are held at 0 from the next clock edge of their domain. When `pwr_en` goes high, the first pulse comes exactly N (or R) enabled edges later. That count uses the setting present at the last held edge.
- R7: `ref_div2` toggles on the `ref_clk` edge that follows each `ref_pulse`.
- R8: `prog_div2` toggles on the `vco_clk` edge that follows each `prog_pulse`.
- R9: `ref_div512` toggles on the `ref_clk` edge that follows every 256th `ref_pulse` counted since enable, so its period is 512 reference pulses.
- R10: A low `rst_n` clears all outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Oscillator clock, the input of the programmable counter |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pwr_en | input | 1 | Power-up enable; low holds both counters cleared |
| mc_code | input | 2 | Main-counter ratio code |
| sc_val | input | 5 | Swallow count S |
| rc_code | input | 2 | Reference ratio code |
| prog_pulse | output | 1 | Programmable-counter pulse to the phase detector |
| ref_pulse | output | 1 | Reference-counter pulse to the phase detector |
| prog_div2 | output | 1 | Test: programmable pulses divided by 2 |
| ref_div2 | output | 1 | Test: reference pulses divided by 2 |
| ref_div512 | output | 1 | Test: reference pulses divided by 512 |

## Verification
The hardest case to reach is a setting change that lands partway through a period. It has to arrive after the counter has latched its old value and before the period ends. A change applied too early would look the same from the ports as one applied at the right time. The stimulus therefore waits for a pulse and then moves the codes a few dozen cycles into the next period. It does the same for a power-down that is held while new codes are loaded. The ÷512 output needs hundreds of uninterrupted reference pulses before it toggles. So the long directed runs use the shortest reference ratio, and the random phases only sometimes drop the enable.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  // reference ratio selection; the code-to-ratio mapping is behaviour
  typedef logic [1:0] ref_sel_t;

  localparam int unsigned REF_MIN = 3;
  localparam int unsigned REF_MAX = 8;
  localparam int unsigned REF_W   = $clog2(REF_MAX + 1);

  function automatic int unsigned ref_ratio(input ref_sel_t sel);
    int unsigned r;
    unique case (sel)
      2'b00:   r = 3;
      2'b01:   r = 4;
      2'b10:   r = 6;
      default: r = 8;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pswd_prescaler.sv
// Dual-modulus prescaler: LOW_MOD or LOW_MOD+1 clocks per cycle.
module pswd_prescaler #(
  parameter int unsigned LOW_MOD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_cyc,
  output logic cyc_end
);
  localparam int unsigned CW = $clog2(LOW_MOD + 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(LOW_MOD - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(LOW_MOD);

  logic [CW-1:0] cnt_q;

  assign cyc_end = run && (cnt_q == (long_cyc ? LAST_LONG : LAST_SHORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || cyc_end) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswd_prog_counter.sv
// Main plus swallow counters around the prescaler; N = LOW_MOD*M + S.
module pswd_prog_counter #(
  parameter int unsigned LOW_MOD = 32,
  parameter int unsigned MC_BASE = 32,
  parameter int unsigned MC_W    = 2,
  parameter int unsigned SC_W    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [MC_W-1:0] mc_code,
  input  logic [SC_W-1:0] sc_val,
  output logic            pulse_o
);
  localparam int unsigned MC_MAX = MC_BASE + (1 << MC_W) - 1;
  localparam int unsigned MW     = $clog2(MC_MAX + 1);

  logic [MW-1:0]   main_q;
  logic [MW-1:0]   mc_lat_q;
  logic [SC_W-1:0] swal_q;
  logic            pre_end;
  logic            main_end;
  logic            period_end;
  logic            long_cyc;

  // prescaler runs at the long modulus while swallow cycles remain
  assign long_cyc = (swal_q != '0);

  pswd_prescaler #(.LOW_MOD(LOW_MOD)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .long_cyc (long_cyc),
    .cyc_end  (pre_end)
  );

  assign main_end   = (main_q == mc_lat_q - 1'b1);
  assign period_end = pre_end && main_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q   <= '0;
      mc_lat_q <= MW'(MC_BASE);
      swal_q   <= '0;
      pulse_o  <= 1'b0;
    end else if (!run || period_end) begin
      // period boundary (or held): take the new setting
      main_q   <= '0;
      mc_lat_q <= MW'(MC_BASE) + MW'(mc_code);
      swal_q   <= sc_val;
      pulse_o  <= period_end;
    end else begin
      pulse_o <= 1'b0;
      if (pre_end) begin
        main_q <= main_q + 1'b1;
        if (long_cyc) swal_q <= swal_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pswd_ref_counter.sv
module pswd_ref_counter
  import pswd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  ref_sel_t sel,
  output logic     pulse_o
);
  logic [REF_W-1:0] cnt_q;
  logic [REF_W-1:0] lim_q;
  logic             term;

  assign term = run && (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lim_q   <= REF_W'(ref_ratio(2'b00));
      pulse_o <= 1'b0;
    end else if (!run || term) begin
      cnt_q   <= '0;
      lim_q   <= REF_W'(ref_ratio(sel));
      pulse_o <= term;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pswd_toggle_div.sv
// Square wave that flips after every HALF input ticks.
module pswd_toggle_div #(
  parameter int unsigned HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic q
);
  generate
    if (HALF <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (!run) q <= 1'b0;
        else if (tick) q <= ~q;
      end
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] n_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          n_q <= '0;
          q   <= 1'b0;
        end else if (!run) begin
          n_q <= '0;
          q   <= 1'b0;
        end else if (tick) begin
          if (n_q == CW'(HALF - 1)) begin
            n_q <= '0;
            q   <= ~q;
          end else begin
            n_q <= n_q + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pswallow_divpair.sv
module pswallow_divpair
  import pswd_pkg::*;
#(
  parameter int unsigned LOW_MOD  = 32,
  parameter int unsigned MC_BASE  = 32,
  parameter int unsigned MC_W     = 2,
  parameter int unsigned SC_W     = 5,
  parameter int unsigned SLOW_DIV = 512
) (
  input  logic            vco_clk,
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            pwr_en,
  input  logic [MC_W-1:0] mc_code,
  input  logic [SC_W-1:0] sc_val,
  input  logic [1:0]      rc_code,
  output logic            prog_pulse,
  output logic            ref_pulse,
  output logic            prog_div2,
  output logic            ref_div2,
  output logic            ref_div512
);
  localparam int unsigned SLOW_HALF = SLOW_DIV / 2;

  pswd_prog_counter #(
    .LOW_MOD (LOW_MOD),
    .MC_BASE (MC_BASE),
    .MC_W    (MC_W),
    .SC_W    (SC_W)
  ) u_prog (
    .clk     (vco_clk),
    .rst_n   (rst_n),
    .run     (pwr_en),
    .mc_code (mc_code),
    .sc_val  (sc_val),
    .pulse_o (prog_pulse)
  );

  pswd_ref_counter u_ref (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .run     (pwr_en),
    .sel     (rc_code),
    .pulse_o (ref_pulse)
  );

  pswd_toggle_div #(.HALF(1)) u_prog_d2 (
    .clk (vco_clk), .rst_n (rst_n), .run (pwr_en), .tick (prog_pulse), .q (prog_div2)
  );

  pswd_toggle_div #(.HALF(1)) u_ref_d2 (
    .clk (ref_clk), .rst_n (rst_n), .run (pwr_en), .tick (ref_pulse), .q (ref_div2)
  );

  pswd_toggle_div #(.HALF(SLOW_HALF)) u_ref_dslow (
    .clk (ref_clk), .rst_n (rst_n), .run (pwr_en), .tick (ref_pulse), .q (ref_div512)
  );
endmodule

// File: rtl/pswallow_divpair_chk.sv
module pswallow_divpair_chk
  import pswd_pkg::*;
#(
  parameter int unsigned LOW_MOD = 32,
  parameter int unsigned MC_BASE = 32,
  parameter int unsigned MC_W    = 2,
  parameter int unsigned SC_W    = 5
) (
  input logic vco_clk,
  input logic ref_clk,
  input logic rst_n,
  input logic pwr_en,
  input logic prog_pulse,
  input logic ref_pulse,
  input logic prog_div2,
  input logic ref_div2,
  input logic ref_div512
);
  localparam int unsigned N_MIN = LOW_MOD * MC_BASE;
  localparam int unsigned N_MAX = LOW_MOD * (MC_BASE + (1 << MC_W) - 1) + (1 << SC_W) - 1;
  localparam int unsigned NW    = $clog2(N_MAX + 2);
  localparam int unsigned RCW   = REF_W + 1;

  logic [NW-1:0]  v_cnt;
  logic [RCW-1:0] r_cnt;

  // enabled cycles since the last pulse, saturating
  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n || !pwr_en) v_cnt <= '0;
    else if (prog_pulse)    v_cnt <= NW'(1);
    else if (v_cnt != '1)   v_cnt <= v_cnt + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n || !pwr_en) r_cnt <= '0;
    else if (ref_pulse)     r_cnt <= RCW'(1);
    else if (r_cnt != '1)   r_cnt <= r_cnt + 1'b1;
  end

  p_prog_period_r1: assert property (@(posedge vco_clk) disable iff (!rst_n)
    prog_pulse |-> (v_cnt >= NW'(N_MIN)) && (v_cnt <= NW'(N_MAX)));

  p_prog_single_r1: assert property (@(posedge vco_clk) disable iff (!rst_n)
    prog_pulse |=> !prog_pulse);

  p_ref_period_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |-> (r_cnt >= RCW'(REF_MIN)) && (r_cnt <= RCW'(REF_MAX)));

  p_ref_single_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  p_prog_hold_r6: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !pwr_en |=> !prog_pulse && !prog_div2);

  p_ref_hold_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pwr_en |=> !ref_pulse && !ref_div2 && !ref_div512);

  p_ref_div2_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(ref_div2) |-> $past(ref_pulse) || !$past(pwr_en));

  p_prog_div2_r8: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(prog_div2) |-> $past(prog_pulse) || !$past(pwr_en));

  p_ref_div512_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(ref_div512) |-> $past(ref_pulse) || !$past(pwr_en));
endmodule

bind pswallow_divpair pswallow_divpair_chk #(
  .LOW_MOD (LOW_MOD),
  .MC_BASE (MC_BASE),
  .MC_W    (MC_W),
  .SC_W    (SC_W)
) u_chk (
  .vco_clk    (vco_clk),
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .pwr_en     (pwr_en),
  .prog_pulse (prog_pulse),
  .ref_pulse  (ref_pulse),
  .prog_div2  (prog_div2),
  .ref_div2   (ref_div2),
  .ref_div512 (ref_div512)
);

// File: tb/test_pswallow_divpair.sv
module test_pswallow_divpair;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b1;
  logic       pwr_en  = 1'b0;
  logic [1:0] mc_code = 2'b10;
  logic [4:0] sc_val  = 5'd1;
  logic [1:0] rc_code = 2'b00;
  logic       prog_pulse, ref_pulse, prog_div2, ref_div2, ref_div512;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string v_tag  = "R1";
  string r_tag  = "R4";

  always #10 vco_clk = ~vco_clk;   // 50 MHz
  always #15 ref_clk = ~ref_clk;

  pswallow_divpair i_pswallow_divpair (
    .vco_clk (vco_clk), .ref_clk (ref_clk), .rst_n (rst_n), .pwr_en (pwr_en),
    .mc_code (mc_code), .sc_val (sc_val), .rc_code (rc_code),
    .prog_pulse (prog_pulse), .ref_pulse (ref_pulse), .prog_div2 (prog_div2),
    .ref_div2 (ref_div2), .ref_div512 (ref_div512)
  );

  function automatic int n_of(input logic [1:0] m, input logic [4:0] s);
    return 32 * (32 + int'(m)) + int'(s);
  endfunction

  function automatic int r_of(input logic [1:0] c);
    case (c)
      2'b00:   return 3;
      2'b01:   return 4;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails <= 20) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // oscillator-domain model, sampled 1 ns after each rising edge
  initial begin
    int v_cnt = 0;
    int v_exp = 0;
    bit v_t2  = 1'b0;
    forever begin
      @(posedge vco_clk); #1;
      if (!rst_n || !pwr_en) begin
        chk(!prog_pulse && !prog_div2, rst_n ? "R6" : "R10", {prog_pulse, prog_div2}, 0);
        v_cnt = 0; v_exp = n_of(mc_code, sc_val); v_t2 = 1'b0;
      end else begin
        v_cnt++;
        chk(prog_div2 == v_t2, "R8", prog_div2, v_t2);
        if (prog_pulse) begin
          chk(v_cnt == v_exp, v_tag, v_cnt, v_exp);   // R1 period length
          v_cnt = 0; v_exp = n_of(mc_code, sc_val); v_t2 = ~v_t2;
        end else if (v_cnt == v_exp + 1) begin
          chk(1'b0, v_tag, v_cnt, v_exp);             // R1 pulse missing
        end
      end
    end
  end

  // reference-domain model
  initial begin
    int r_cnt = 0;
    int r_exp = 0;
    int r_pc  = 0;
    bit r_t2  = 1'b0;
    bit r_t9  = 1'b0;
    forever begin
      @(posedge ref_clk); #1;
      if (!rst_n || !pwr_en) begin
        chk(!ref_pulse && !ref_div2 && !ref_div512, rst_n ? "R6" : "R10",
            {ref_pulse, ref_div2, ref_div512}, 0);
        r_cnt = 0; r_exp = r_of(rc_code); r_pc = 0; r_t2 = 1'b0; r_t9 = 1'b0;
      end else begin
        r_cnt++;
        chk(ref_div2 == r_t2, "R7", ref_div2, r_t2);
        chk(ref_div512 == r_t9, "R9", ref_div512, r_t9);
        if (ref_pulse) begin
          chk(r_cnt == r_exp, r_tag, r_cnt, r_exp);   // R4 period length
          r_cnt = 0; r_exp = r_of(rc_code); r_t2 = ~r_t2;
          r_pc++;
          if (r_pc == 256) begin r_pc = 0; r_t9 = ~r_t9; end
        end else if (r_cnt == r_exp + 1) begin
          chk(1'b0, r_tag, r_cnt, r_exp);
        end
      end
    end
  end

  task automatic vco_wait(input int n);
    repeat (n) @(posedge vco_clk);
    #2;
  endtask

  task automatic set_vco(input logic [1:0] m, input logic [4:0] s);
    vco_wait(1);
    mc_code = m; sc_val = s;
  endtask

  task automatic set_ref(input logic [1:0] c);
    @(posedge ref_clk); #2;
    rc_code = c;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd20811));
    #1 rst_n = 1'b0;
    vco_wait(4);
    // R10: all outputs cleared under reset
    chk({prog_pulse, ref_pulse, prog_div2, ref_div2, ref_div512} == 5'b0, "R10",
        {prog_pulse, ref_pulse, prog_div2, ref_div2, ref_div512}, 0);
    rst_n = 1'b1;
    vco_wait(3);
    // R3: transmit channel, M=34 S=1; R4 with ratio 3
    v_tag = "R3"; r_tag = "R4";
    pwr_en = 1'b1;
    vco_wait(3500);
    // R3: top transmit channel S=31
    set_vco(2'b10, 5'd31); set_ref(2'b01);
    vco_wait(3500);
    // R3: receive channel M=32 with S=0 (all long-modulus free)
    set_vco(2'b00, 5'd0); set_ref(2'b10);
    vco_wait(3500);
    // R2: largest ratio M=35 S=31, and M=33
    v_tag = "R2";
    set_vco(2'b11, 5'd31); set_ref(2'b11);
    vco_wait(3500);
    set_vco(2'b01, 5'd17); set_ref(2'b00);
    vco_wait(3000);
    // R5: change just after a boundary, old length must finish
    v_tag = "R5"; r_tag = "R5";
    do vco_wait(1); while (!prog_pulse);
    vco_wait(40);
    set_vco(2'b11, 5'd3);
    set_ref(2'b11);
    do begin @(posedge ref_clk); #2; end while (!ref_pulse);
    @(posedge ref_clk); #2;
    rc_code = 2'b00;
    vco_wait(3000);
    // R6: power-down mid-period, new codes loaded while held
    v_tag = "R6"; r_tag = "R6";
    vco_wait(400);
    pwr_en = 1'b0;
    vco_wait(20);
    mc_code = 2'b00; sc_val = 5'd9; rc_code = 2'b01;
    vco_wait(17);
    pwr_en = 1'b1;
    vco_wait(3000);
    // R10: asynchronous reset in mid-run
    vco_wait(123);
    rst_n = 1'b0; pwr_en = 1'b0;
    #1;
    chk({prog_pulse, ref_pulse, prog_div2, ref_div2, ref_div512} == 5'b0, "R10",
        {prog_pulse, ref_pulse, prog_div2, ref_div2, ref_div512}, 0);
    vco_wait(5);
    rst_n = 1'b1;
    vco_wait(4);
    pwr_en = 1'b1;
    // R1 / R4: random settings and timing
    v_tag = "R1"; r_tag = "R4";
    for (int i = 0; i < 14; i++) begin
      set_vco(2'($urandom % 4), 5'($urandom % 32));
      set_ref(2'($urandom % 4));
      if ($urandom % 4 == 0) begin
        vco_wait(1);
        pwr_en = 1'b0;
        vco_wait(3 + $urandom % 30);
        pwr_en = 1'b1;
      end
      vco_wait(1200 + $urandom % 2500);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(64'd3_500_000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule